// File: doc/BRIEF.md
# Security-Tagged Cache Tag Lookup

This block holds the tag store and hit/miss decision for a small set-associative cache, either one or two ways. Each stored line has a security bit next to its address tag. Lines that belong to the secure address space and lines that belong to the non-secure address space sit side by side in the same array.

A requester presents an address, a non-secure attribute and the security state of the world issuing the request. The block works out the effective non-secure value for that request and compares it together with the address tag. One cycle later it reports hit or miss, and on a hit it also reports the way.

When a miss is reported, the surrounding refill logic pulses an allocate strobe. That strobe writes the most recently looked-up request into the way chosen by a per-set round-robin pointer. A single invalidate input empties the whole array in one cycle. Data storage, refill and write-back are handled elsewhere.

Top module: `sec_tag_lookup`

## Requirements
- R1: While reset is held and in the cycle after it, hit and miss are 0. Every line starts invalid, so the first lookup after reset misses.
- R2: A request sampled on a clock edge produces exactly one of hit or miss, high for the one cycle after that edge. A cycle with no request produces neither.
- R3: Address fields are: offset in bits [3:0], set index in bits [6:4], tag in bits [31:7]. A lookup hits only if a valid line in the indexed set matches both the tag and the effective non-secure bit. On a hit, hit_way gives that way (0 or 1); otherwise hit_way is 0.
- R4: A request from the normal world (req_world_secure=0) always uses an effective non-secure bit of 1, whatever req_ns_attr holds.
- R5: A request from the secure world (req_world_secure=1) uses req_ns_attr as its effective non-secure bit. 0 selects a secure line and 1 selects a non-secure line.
- R6: A lookup with effective non-secure bit 1 to an address held only as a secure line misses.
- R7: An allocate strobe writes the tag, set and effective non-secure bit of the most recent request into the victim way and marks that line valid. A secure line and a non-secure line for the same address can be valid at the same time.
- R8: Each set has its own victim pointer. The pointer is 0 after reset and toggles on every allocate to that set. Allocates to other sets leave it unchanged.
- R9: invalidate_all clears every valid bit at the next edge. It wins over an allocate strobe raised in the same cycle, so nothing is written.
- R10: A change of the requesting world invalidates no line. Lines stay valid while lookups alternate between worlds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Physical address of the request |
| req_ns_attr | input | 1 | Non-secure attribute supplied by the requester |
| req_world_secure | input | 1 | 1 when the issuing world is secure |
| alloc_valid | input | 1 | Allocate the most recent request into the victim way |
| invalidate_all | input | 1 | Clear every valid bit |
| hit | output | 1 | Registered hit result |
| miss | output | 1 | Registered miss result |
| hit_way | output | 1 | Way that hit, 0 when there is no hit |

## Verification
The central corner case is the same address looked up under both security states. A secure allocate followed by a non-secure lookup must miss, and a design that leaves the security bit out of the compare would wrongly hit. A later non-secure allocate must land in the other way so that both copies hit; a design without a working round-robin pointer would overwrite the secure copy. The bench sends normal-world requests with attribute 0, which must be treated as non-secure; a design that passes the attribute straight through would hit the secure line. It also checks that a set's pointer is unaffected by allocates to other sets, and that invalidate beats a simultaneous allocate. A design that lets the allocate through would hit afterwards.

// File: rtl/sec_tag_pkg.sv
// Package: shared helpers for the security-tagged tag lookup.
// Assumes: a non-secure value of 1 means the non-secure address space.
package sec_tag_pkg;

    // Effective non-secure bit: the normal world can only issue non-secure accesses.
    function automatic logic eff_ns(input logic world_secure, input logic ns_attr);
        return (!world_secure) | ns_attr;
    endfunction

endpackage

// File: rtl/sec_tag_way.sv
// Module: one way of the tag store. It holds valid, non-secure and tag per set,
// and compares one lookup against the indexed set.
// Assumes: clear takes priority over write; a lookup sees contents from before the edge.
module sec_tag_way #(
    parameter int SETS  = 8,
    parameter int SET_W = 3,
    parameter int TAG_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic             lk_ns,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_ns,
    output logic             match
);

    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  ns_q;
    logic [TAG_W-1:0] tag_q [SETS];

    // Valid bits: cleared by reset or clear, set by a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= '0;
        else if (clr)
            valid_q <= '0;
        else if (wr_en)
            valid_q[wr_set] <= 1'b1;
    end

    // Tag and security bit storage, written on allocate.
    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            tag_q[wr_set] <= wr_tag;
            ns_q[wr_set]  <= wr_ns;
        end
    end

    // Compare: a valid line with the same tag and the same security bit.
    always_comb begin
        match = valid_q[lk_set] && (tag_q[lk_set] == lk_tag) && (ns_q[lk_set] == lk_ns);
    end

    // The clear empties the whole way at the next edge.
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ($countones(valid_q) == 0));

    // A write without a clear leaves the written line valid.
    assert_write_sets_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> valid_q[$past(wr_set)]);

endmodule

// File: rtl/sec_tag_victim.sv
// Module: per-set victim choice. With two ways it keeps one round-robin bit per
// set that toggles on each allocate to that set; with one way the victim is always 0.
// Assumes: WAYS is 1 or 2.
module sec_tag_victim #(
    parameter int SETS  = 8,
    parameter int SET_W = 3,
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [SET_W-1:0] adv_set,
    output logic [WAY_W-1:0] victim
);

    generate
        if (WAYS == 2) begin : g_rr
            logic [SETS-1:0] rr_q;

            // Round-robin pointers: reset to way 0, toggle on allocate.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    rr_q <= '0;
                else if (adv)
                    rr_q[adv_set] <= ~rr_q[adv_set];
            end

            // Victim for the set being allocated.
            always_comb begin
                victim = WAY_W'(rr_q[adv_set]);
            end

            // An allocate moves that set's pointer to the other way.
            assert_rr_toggles_R8: assert property (@(posedge clk) disable iff (!rst_n)
                adv |=> (rr_q[$past(adv_set)] != $past(rr_q[adv_set])));

            // Without an allocate no pointer moves.
            assert_rr_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !adv |=> $stable(rr_q));
        end else begin : g_single
            // Direct-mapped: only one way to choose.
            always_comb begin
                victim = '0;
            end
        end
    endgenerate

endmodule

// File: rtl/sec_tag_lookup.sv
// Module: top of the security-tagged tag lookup. It derives the effective
// non-secure bit, compares it with every way, registers hit/miss/hit_way and
// steers allocates from the last captured request into the victim way.
// Assumes: alloc_valid follows a reported miss before the next request;
// invalidate_all beats a simultaneous allocate.
module sec_tag_lookup
    import sec_tag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4,
    parameter int SET_W  = 3,
    parameter int WAYS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_ns_attr,
    input  logic              req_world_secure,
    input  logic              alloc_valid,
    input  logic              invalidate_all,
    output logic              hit,
    output logic              miss,
    output logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0] hit_way
);

    localparam int SETS  = 1 << SET_W;
    localparam int TAG_W = ADDR_W - OFF_W - SET_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [SET_W-1:0] lk_set;
    logic [TAG_W-1:0] lk_tag;
    logic             lk_ns;
    logic [WAYS-1:0]  way_match;
    logic             any_hit;
    logic [WAY_W-1:0] sel_way;

    logic [SET_W-1:0] cap_set_q;
    logic [TAG_W-1:0] cap_tag_q;
    logic             cap_ns_q;

    logic             alloc_go;
    logic [WAY_W-1:0] victim;

    // Split the request address and resolve its effective security bit.
    always_comb begin
        lk_set = req_addr[OFF_W +: SET_W];
        lk_tag = req_addr[ADDR_W-1 -: TAG_W];
        lk_ns  = eff_ns(req_world_secure, req_ns_attr);
    end

    // An allocate is carried out only when no invalidate competes with it.
    always_comb begin
        alloc_go = alloc_valid && !invalidate_all;
    end

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            sec_tag_way #(
                .SETS  (SETS),
                .SET_W (SET_W),
                .TAG_W (TAG_W)
            ) way_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr    (invalidate_all),
                .lk_set (lk_set),
                .lk_tag (lk_tag),
                .lk_ns  (lk_ns),
                .wr_en  (alloc_go && (victim == WAY_W'(w))),
                .wr_set (cap_set_q),
                .wr_tag (cap_tag_q),
                .wr_ns  (cap_ns_q),
                .match  (way_match[w])
            );
        end
    endgenerate

    sec_tag_victim #(
        .SETS  (SETS),
        .SET_W (SET_W),
        .WAYS  (WAYS),
        .WAY_W (WAY_W)
    ) victim_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (alloc_go),
        .adv_set (cap_set_q),
        .victim  (victim)
    );

    // Pick the lowest-numbered matching way.
    always_comb begin
        any_hit = 1'b0;
        sel_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!any_hit && way_match[w]) begin
                any_hit = 1'b1;
                sel_way = WAY_W'(w);
            end
        end
    end

    // Register the lookup result for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit     <= 1'b0;
            miss    <= 1'b0;
            hit_way <= '0;
        end else begin
            hit     <= req_valid && any_hit;
            miss    <= req_valid && !any_hit;
            hit_way <= (req_valid && any_hit) ? sel_way : '0;
        end
    end

    // Capture the last request so a later allocate knows what to write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_set_q <= '0;
            cap_tag_q <= '0;
            cap_ns_q  <= 1'b0;
        end else if (req_valid) begin
            cap_set_q <= lk_set;
            cap_tag_q <= lk_tag;
            cap_ns_q  <= lk_ns;
        end
    end

    // Every request gets exactly one answer in the next cycle.
    assert_one_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (hit ^ miss));

    // No request means no answer.
    assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!hit && !miss));

    // Normal-world requests are recorded as non-secure.
    assert_normal_is_ns_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_world_secure) |=> cap_ns_q);

    // The way number is zero unless there is a hit.
    assert_way_zero_on_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_way == '0));

endmodule

// File: tb/sec_tag_lookup_tb_top.sv
// Bench: table-driven lookups and allocates, then directed reset and corner tests.
module sec_tag_lookup_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ns_attr = 1'b0;
    logic        req_world_secure = 1'b0;
    logic        alloc_valid = 1'b0;
    logic        invalidate_all = 1'b0;
    logic        hit;
    logic        miss;
    logic [0:0]  hit_way;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    sec_tag_lookup dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .req_valid        (req_valid),
        .req_addr         (req_addr),
        .req_ns_attr      (req_ns_attr),
        .req_world_secure (req_world_secure),
        .alloc_valid      (alloc_valid),
        .invalidate_all   (invalidate_all),
        .hit              (hit),
        .miss             (miss),
        .hit_way          (hit_way)
    );

    localparam logic [1:0] OP_LK  = 2'd0;
    localparam logic [1:0] OP_LKA = 2'd1;
    localparam logic [1:0] OP_INV = 2'd2;

    localparam logic [31:0] AD_A = 32'h0000_1230; // set 3
    localparam logic [31:0] AD_B = 32'h0000_12B0; // set 3, other tag
    localparam logic [31:0] AD_C = 32'h0000_1250; // set 5
    localparam logic [31:0] AD_D = 32'h0000_0010; // set 1

    // {op, addr, ns_attr, world_secure, exp_hit, exp_way, requirement}
    localparam int NV = 19;
    localparam logic [41:0] VEC [NV] = '{
        {OP_LK,  AD_A, 1'b1, 1'b0, 1'b0, 1'b0, 4'd1},  // R1 empty after reset
        {OP_LKA, AD_A, 1'b0, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 secure line into way 0
        {OP_LK,  AD_A, 1'b0, 1'b1, 1'b1, 1'b0, 4'd3},  // R3 secure hit way 0
        {OP_LK,  AD_A, 1'b1, 1'b1, 1'b0, 1'b0, 4'd6},  // R6 ns lookup misses secure line
        {OP_LK,  AD_A, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 normal world forced ns
        {OP_LKA, AD_A, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 ns line into way 1
        {OP_LK,  AD_A, 1'b1, 1'b0, 1'b1, 1'b1, 4'd4},  // R4 normal hit way 1
        {OP_LK,  AD_A, 1'b0, 1'b1, 1'b1, 1'b0, 4'd10}, // R10 secure copy still there
        {OP_LK,  AD_A, 1'b1, 1'b1, 1'b1, 1'b1, 4'd5},  // R5 secure world ns access
        {OP_LK,  AD_B, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 tag mismatch
        {OP_LKA, AD_B, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 pointer back at way 0
        {OP_LK,  AD_A, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 secure A evicted
        {OP_LK,  AD_B, 1'b1, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 B in way 0
        {OP_LK,  AD_A, 1'b1, 1'b0, 1'b1, 1'b1, 4'd8},  // R8 ns A kept in way 1
        {OP_LKA, AD_C, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 set 5 pointer independent
        {OP_LK,  AD_C, 1'b0, 1'b1, 1'b1, 1'b0, 4'd8},  // R8 C in way 0
        {OP_INV, AD_A, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 invalidate
        {OP_LK,  AD_A, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 gone
        {OP_LK,  AD_C, 1'b0, 1'b1, 1'b0, 1'b0, 4'd9}   // R9 gone
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Present one request; return at the negedge where the result is visible.
    task automatic lookup(input logic [31:0] a, input logic ns, input logic ws);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_ns_attr = ns; req_world_secure = ws;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_result(input string req, input logic eh, input logic ew);
        check(req, "hit", int'(hit), int'(eh));
        check(req, "miss", int'(miss), int'(!eh));
        check(req, "hit_way", int'(hit_way), eh ? int'(ew) : 0);
    endtask

    task automatic pulse_alloc(input logic with_inv);
        alloc_valid = 1'b1; invalidate_all = with_inv;
        @(negedge clk);
        alloc_valid = 1'b0; invalidate_all = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "hit in reset", int'(hit), 0);
        check("R1", "miss in reset", int'(miss), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "hit after reset", int'(hit), 0);
        check("R1", "miss after reset", int'(miss), 0);

        for (int i = 0; i < NV; i++) begin
            logic [41:0] v;
            string rq;
            v  = VEC[i];
            rq = $sformatf("R%0d", v[3:0]);
            if (v[41:40] == OP_INV) begin
                @(negedge clk);
                invalidate_all = 1'b1;
                @(negedge clk);
                invalidate_all = 1'b0;
            end else begin
                lookup(v[39:8], v[7], v[6]);
                expect_result(rq, v[5], v[4]);
                if (v[41:40] == OP_LKA)
                    pulse_alloc(1'b0);
            end
        end

        // R2: an idle cycle produces no answer.
        lookup(AD_D, 1'b0, 1'b1);
        expect_result("R2", 1'b0, 1'b0);
        @(negedge clk);
        check("R2", "idle hit", int'(hit), 0);
        check("R2", "idle miss", int'(miss), 0);

        // R9: invalidate beats a simultaneous allocate.
        lookup(AD_D, 1'b0, 1'b1);
        expect_result("R9", 1'b0, 1'b0);
        pulse_alloc(1'b1);
        lookup(AD_D, 1'b0, 1'b1);
        expect_result("R9", 1'b0, 1'b0);

        // R7: plain allocate into set 1 then hit.
        pulse_alloc(1'b0);
        lookup(AD_D, 1'b0, 1'b1);
        expect_result("R7", 1'b1, 1'b0);

        // R1: reset mid-run empties the store.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        lookup(AD_D, 1'b0, 1'b1);
        expect_result("R1", 1'b0, 1'b0);

        repeat (2) @(negedge clk);
        finish_up();
    end

endmodule